// File: doc/BRIEF.md
# Dual-clock FIFO with programmable flags

This block buffers 36-bit words between a write clock domain and an independent read clock domain. Words are accepted on rising write-clock edges while write enable is high and the FIFO has room. They leave in the same order on rising read-clock edges. Read and write positions cross between the domains as Gray codes through two-stage synchronisers. Each domain therefore sees the other side's progress a few of its own cycles late, which always errs towards the safe side.

Besides full and empty, the block drives two threshold flags, both active low. The almost-full flag lives in the write domain and the almost-empty flag lives in the read domain. Each compares the fill level with an offset held in a register. While the load strobe is high, a write-enabled edge stores the low bits of the input word into an offset register instead of the memory. A read-enabled edge places an offset on the output bus instead of popping a word. Both directions step through the almost-empty offset first and the almost-full offset second, then wrap back.

A master reset, active low, empties the FIFO, restores both offsets to parameter defaults and samples a mode strap. With the strap low the block runs in standard mode, where every word needs a read strobe to reach the output register. With the strap high it runs in first-word-fall-through mode. In that mode the oldest word is placed on the output by itself, so the output register adds one word of capacity.

Top module: `fifo_pf_top`

## Requirements
- R1: After master reset, fullN=1, emptyN=0, pafN=1, paeN=0, and the two offset readbacks return the almost-empty default and then the almost-full default (both 7 by default), zero-extended to 36 bits.
- R2: In standard mode, words come out in the order written. A read-enabled rising read-clock edge with the FIFO non-empty and the load strobe low puts the next word on dataOut at that edge.
- R3: In standard mode, fullN goes low when DEPTH words are held. A write presented while fullN is low is dropped, and the DEPTH stored words still drain intact.
- R4: A read presented while emptyN is low changes neither dataOut nor the FIFO contents.
- R5: lden=1 with wen=1 on a write-clock edge stores din[AW-1:0] into the almost-empty offset on the first access and into the almost-full offset on the second, alternating afterwards. Memory and flags are untouched.
- R6: lden=1 with ren=1 on a read-clock edge shows an offset on dataOut: almost-empty first, then almost-full, alternating. No stored word is consumed.
- R7: Once the pointers have settled, pafN is low exactly when the write-side memory level is at least DEPTH minus the almost-full offset. After a read that lowers the level below that bound, pafN returns high within four write-clock cycles.
- R8: Once the pointers have settled, paeN is low exactly when the read-side word count (memory level plus, in first-word-fall-through mode, the held output word) is at most the almost-empty offset.
- R9: With fwftPin=1 during reset, the first word appears on dataOut without a read strobe, emptyN is high exactly while a word is held, and DEPTH+1 words are accepted before fullN goes low. Almost-full then asserts at DEPTH+1 minus the offset words.
- R10: While oe=0, dataOut reads as all zeros. Restoring oe=1 shows the held value again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk | input | 1 | Write clock |
| wen | input | 1 | Write enable |
| din | input | 36 | Data word or offset value |
| rclk | input | 1 | Read clock |
| ren | input | 1 | Read enable |
| oe | input | 1 | Output enable, zeros when low |
| dataOut | output | 36 | Output register or offset readback |
| lden | input | 1 | Load strobe: steers accesses to offsets |
| mrstN | input | 1 | Master reset, active low, asynchronous |
| fwftPin | input | 1 | Mode strap sampled during reset |
| fullN | output | 1 | Full, active low (write domain) |
| emptyN | output | 1 | Empty, active low (read domain) |
| pafN | output | 1 | Almost full, active low (write domain) |
| paeN | output | 1 | Almost empty, active low (read domain) |

## Verification
A pointer that skips or repeats shows up on the first read after the fault as a word out of order, duplicated or lost. A pointer that fails to cross the domains shows up as a flag that sticks once the bench has waited a few cycles of both clocks. A wrong offset select appears at the very next readback, which returns the other register. A bad output-register load in fall-through mode is visible on dataOut one read cycle after a word arrives. Flag thresholds are checked at every fill level on both the fill and the drain sweeps, so an off-by-one comparison fails at the single level where it matters.

// File: rtl/fifo_pf_pkg.sv
package fifo_pf_pkg;
  localparam int WORD_W = 36;

  typedef struct packed {
    logic memWr;
    logic ofsWr;
    logic ofsSel;
  } wrStb_t;

  typedef struct packed {
    logic memRd;
    logic ofsRd;
    logic ofsSel;
    logic showClr;
  } rdStb_t;
endpackage

// File: rtl/fifo_pf_sync.sv
module fifo_pf_sync #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/fifo_pf_ctrl.sv
module fifo_pf_ctrl
  import fifo_pf_pkg::*;
#(
  parameter int DEPTH = 1024,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          wclk,
  input  logic          rclk,
  input  logic          mrstN,
  input  logic          fwftPin,
  input  logic          wen,
  input  logic          ren,
  input  logic          lden,
  input  logic [AW-1:0] afOfs,
  input  logic [AW-1:0] aeOfs,
  output wrStb_t        wStb,
  output rdStb_t        rStb,
  output logic [AW-1:0] wAddr,
  output logic [AW-1:0] rAddr,
  output logic          fullN,
  output logic          emptyN,
  output logic          pafN,
  output logic          paeN
);
  localparam int PW = AW + 1;
  localparam logic [PW-1:0] FULL_LVL = PW'(DEPTH);

  function automatic logic [PW-1:0] toGray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] fromGray(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // ---------------- write domain ----------------
  logic [PW-1:0] wBin, wGray, rGraySync, rBinSync, wLevel, afLimit;
  logic          wSel, memFull;

  fifo_pf_sync #(.W(PW)) uRdToWr (
    .clk(wclk), .rstN(mrstN), .d(rGray), .q(rGraySync)
  );

  assign rBinSync = fromGray(rGraySync);
  assign wLevel   = wBin - rBinSync;
  assign memFull  = (wLevel == FULL_LVL);
  assign afLimit  = FULL_LVL - {1'b0, afOfs};

  assign wStb.memWr  = wen && !lden && !memFull;
  assign wStb.ofsWr  = wen && lden;
  assign wStb.ofsSel = wSel;
  assign wAddr       = wBin[AW-1:0];

  always_ff @(posedge wclk or negedge mrstN) begin
    if (!mrstN) begin
      wBin  <= '0;
      wGray <= '0;
      wSel  <= 1'b0;
    end else begin
      if (wStb.memWr) begin
        wBin  <= wBin + 1'b1;
        wGray <= toGray(wBin + 1'b1);
      end
      if (wStb.ofsWr) wSel <= ~wSel;
    end
  end

  assign fullN = !memFull;
  assign pafN  = !(wLevel >= afLimit);

  // ---------------- read domain ----------------
  logic [PW-1:0] rBin, rGray, wGraySync, wBinSync, rLevel;
  logic [PW:0]   rCount;
  logic          rSel, fwftMode, outValid, memAvail, popOut;

  fifo_pf_sync #(.W(PW)) uWrToRd (
    .clk(rclk), .rstN(mrstN), .d(wGray), .q(wGraySync)
  );

  assign wBinSync = fromGray(wGraySync);
  assign rLevel   = wBinSync - rBin;
  assign memAvail = (rLevel != '0);
  assign popOut   = ren && !lden && outValid;

  always_ff @(posedge rclk) begin
    if (!mrstN) fwftMode <= fwftPin;
  end

  always_comb begin
    rStb.ofsRd   = ren && lden;
    rStb.ofsSel  = rSel;
    rStb.showClr = ren && !lden;
    if (fwftMode) rStb.memRd = memAvail && (!outValid || popOut);
    else          rStb.memRd = memAvail && ren && !lden;
  end
  assign rAddr = rBin[AW-1:0];

  always_ff @(posedge rclk or negedge mrstN) begin
    if (!mrstN) begin
      rBin     <= '0;
      rGray    <= '0;
      rSel     <= 1'b0;
      outValid <= 1'b0;
    end else begin
      if (rStb.memRd) begin
        rBin  <= rBin + 1'b1;
        rGray <= toGray(rBin + 1'b1);
      end
      if (rStb.ofsRd) rSel <= ~rSel;
      if (fwftMode) begin
        if (rStb.memRd) outValid <= 1'b1;
        else if (popOut) outValid <= 1'b0;
      end else begin
        outValid <= 1'b0;
      end
    end
  end

  assign rCount = {1'b0, rLevel} + (PW+1)'(fwftMode && outValid);
  assign emptyN = fwftMode ? outValid : memAvail;
  assign paeN   = !(rCount <= {2'b00, aeOfs});

  // ---------------- checks ----------------
  // R3
  no_overflow_chk: assert property (@(posedge wclk) disable iff (!mrstN)
    wLevel <= FULL_LVL);
  // R4
  no_underflow_chk: assert property (@(posedge rclk) disable iff (!mrstN)
    rLevel <= FULL_LVL);
  // R7
  full_in_af_chk: assert property (@(posedge wclk) disable iff (!mrstN)
    !fullN |-> !pafN);
  // R8
  empty_in_ae_chk: assert property (@(posedge rclk) disable iff (!mrstN)
    (!fwftMode && !emptyN) |-> !paeN);
  // R2
  wgray_step_chk: assert property (@(posedge wclk) disable iff (!mrstN)
    $countones(wGray ^ $past(wGray)) <= 1);
  // R2
  rgray_step_chk: assert property (@(posedge rclk) disable iff (!mrstN)
    $countones(rGray ^ $past(rGray)) <= 1);
  // R9
  fwft_fill_chk: assert property (@(posedge rclk) disable iff (!mrstN)
    (fwftMode && memAvail && !outValid) |=> emptyN);
endmodule

// File: rtl/fifo_pf_dpath.sv
module fifo_pf_dpath
  import fifo_pf_pkg::*;
#(
  parameter int DEPTH  = 1024,
  parameter int AW     = $clog2(DEPTH),
  parameter int DEF_AE = 7,
  parameter int DEF_AF = 7
) (
  input  logic              wclk,
  input  logic              rclk,
  input  logic              mrstN,
  input  logic [WORD_W-1:0] din,
  input  wrStb_t            wStb,
  input  logic [AW-1:0]     wAddr,
  input  rdStb_t            rStb,
  input  logic [AW-1:0]     rAddr,
  input  logic              oe,
  output logic [WORD_W-1:0] dataOut,
  output logic [AW-1:0]     afOfs,
  output logic [AW-1:0]     aeOfs
);
  logic [WORD_W-1:0] mem [DEPTH];
  logic [WORD_W-1:0] dout, ofsOut;
  logic              showOfs;

  always_ff @(posedge wclk) begin
    if (wStb.memWr) mem[wAddr] <= din;
  end

  always_ff @(posedge wclk or negedge mrstN) begin
    if (!mrstN) begin
      aeOfs <= AW'(DEF_AE);
      afOfs <= AW'(DEF_AF);
    end else if (wStb.ofsWr) begin
      if (wStb.ofsSel) afOfs <= din[AW-1:0];
      else             aeOfs <= din[AW-1:0];
    end
  end

  always_ff @(posedge rclk or negedge mrstN) begin
    if (!mrstN) dout <= '0;
    else if (rStb.memRd) dout <= mem[rAddr];
  end

  always_ff @(posedge rclk or negedge mrstN) begin
    if (!mrstN) begin
      ofsOut  <= '0;
      showOfs <= 1'b0;
    end else begin
      if (rStb.ofsRd) begin
        ofsOut  <= WORD_W'(rStb.ofsSel ? afOfs : aeOfs);
        showOfs <= 1'b1;
      end else if (rStb.showClr || rStb.memRd) begin
        showOfs <= 1'b0;
      end
    end
  end

  assign dataOut = oe ? (showOfs ? ofsOut : dout) : '0;

  // R6
  ofs_show_chk: assert property (@(posedge rclk) disable iff (!mrstN)
    rStb.ofsRd |=> (showOfs && $stable(dout)));
  // R10
  oe_quiet_chk: assert property (@(posedge rclk) disable iff (!mrstN)
    !oe |-> (dataOut == '0));
endmodule

// File: rtl/fifo_pf_top.sv
module fifo_pf_top
  import fifo_pf_pkg::*;
#(
  parameter int DEPTH  = 1024,
  parameter int DEF_AE = 7,
  parameter int DEF_AF = 7
) (
  input  logic              wclk,
  input  logic              wen,
  input  logic [WORD_W-1:0] din,
  input  logic              rclk,
  input  logic              ren,
  input  logic              oe,
  output logic [WORD_W-1:0] dataOut,
  input  logic              lden,
  input  logic              mrstN,
  input  logic              fwftPin,
  output logic              fullN,
  output logic              emptyN,
  output logic              pafN,
  output logic              paeN
);
  localparam int AW = $clog2(DEPTH);

  wrStb_t        wStb;
  rdStb_t        rStb;
  logic [AW-1:0] wAddr, rAddr, afOfs, aeOfs;

  fifo_pf_ctrl #(.DEPTH(DEPTH), .AW(AW)) u_ctrl (
    .wclk(wclk), .rclk(rclk), .mrstN(mrstN), .fwftPin(fwftPin),
    .wen(wen), .ren(ren), .lden(lden), .afOfs(afOfs), .aeOfs(aeOfs),
    .wStb(wStb), .rStb(rStb), .wAddr(wAddr), .rAddr(rAddr),
    .fullN(fullN), .emptyN(emptyN), .pafN(pafN), .paeN(paeN)
  );

  fifo_pf_dpath #(.DEPTH(DEPTH), .AW(AW), .DEF_AE(DEF_AE), .DEF_AF(DEF_AF)) u_dpath (
    .wclk(wclk), .rclk(rclk), .mrstN(mrstN), .din(din),
    .wStb(wStb), .wAddr(wAddr), .rStb(rStb), .rAddr(rAddr),
    .oe(oe), .dataOut(dataOut), .afOfs(afOfs), .aeOfs(aeOfs)
  );
endmodule

// File: tb/fifo_pf_top_bench.sv
module fifo_pf_top_bench;
  localparam int  DEPTH   = 32;
  localparam int  DEF_AE  = 7;
  localparam int  DEF_AF  = 7;
  localparam int  NEW_AE  = 4;
  localparam int  NEW_AF  = 6;
  localparam time CLK_W   = 10;
  localparam time CLK_R   = 14;
  localparam int  RND_LEN = 3000;

  logic        wclk = 0, rclk = 0;
  logic        wen = 0, ren = 0, oe = 1, lden = 0, mrstN = 0, fwftPin = 0;
  logic [35:0] din = '0;
  logic [35:0] dataOut;
  logic        fullN, emptyN, pafN, paeN;

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [35:0] q[$];
  bit wrDone;

  always #(CLK_W/2) wclk = ~wclk;
  always #(CLK_R/2) rclk = ~rclk;

  fifo_pf_top #(.DEPTH(DEPTH), .DEF_AE(DEF_AE), .DEF_AF(DEF_AF)) u_fifo_pf_top (
    .wclk(wclk), .wen(wen), .din(din), .rclk(rclk), .ren(ren), .oe(oe),
    .dataOut(dataOut), .lden(lden), .mrstN(mrstN), .fwftPin(fwftPin),
    .fullN(fullN), .emptyN(emptyN), .pafN(pafN), .paeN(paeN)
  );

  function automatic logic expPafN(int lvl, int m);
    return !(lvl >= DEPTH - m);
  endfunction
  function automatic logic expPaeN(int cnt, int n);
    return !(cnt <= n);
  endfunction
  function automatic logic [35:0] pattern(int k);
    return {4'h5, 32'(k * 32'h0101_0003)};
  endfunction

  task automatic chk(string tag, logic [35:0] act, logic [35:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic doReset(bit mode);
    mrstN = 0; fwftPin = mode; wen = 0; ren = 0; lden = 0;
    repeat (4) @(negedge rclk);
    repeat (4) @(negedge wclk);
    mrstN = 1;
    repeat (3) @(negedge rclk);
  endtask

  task automatic settle();
    repeat (6) @(negedge rclk);
    repeat (6) @(negedge wclk);
  endtask

  task automatic writeWord(logic [35:0] d);
    @(negedge wclk); din = d; wen = 1; lden = 0;
    @(negedge wclk); wen = 0;
  endtask

  task automatic readWord();
    @(negedge rclk); ren = 1; lden = 0;
    @(negedge rclk); ren = 0;
  endtask

  task automatic loadOfs(int v);
    @(negedge wclk); din = 36'(v); wen = 1; lden = 1;
    @(negedge wclk); wen = 0; lden = 0;
  endtask

  task automatic readOfs(output logic [35:0] v);
    @(negedge rclk); ren = 1; lden = 1;
    @(negedge rclk); ren = 0; lden = 0;
    v = dataOut;
  endtask

  task automatic randomTraffic(bit fwft);
    bit pend;
    logic [35:0] expd;
    pend = 0; wrDone = 0;
    fork
      begin
        for (int i = 0; i < RND_LEN; i++) begin
          @(negedge wclk);
          wen = 0;
          if (fullN && ($urandom % 3 != 0)) begin
            din = {4'($urandom), 32'($urandom)};
            wen = 1;
            q.push_back(din);
          end
        end
        @(negedge wclk); wen = 0;
        wrDone = 1;
      end
      begin
        for (int g = 0; g < 4 * RND_LEN; g++) begin
          @(negedge rclk);
          if (fwft) begin
            ren = 0;
            if (emptyN) begin
              if (q.size() == 0) chk("R9 fwft random surplus word", dataOut, 36'h0);
              else begin
                chk("R9 fwft random order", dataOut, q[0]);
                if ($urandom % 2 == 0) begin ren = 1; void'(q.pop_front()); end
              end
            end
            if (wrDone && q.size() == 0 && !ren) break;
          end else begin
            if (pend) begin chk("R2 random order", dataOut, expd); pend = 0; end
            ren = 0;
            if (emptyN && ($urandom % 2 == 0)) begin
              if (q.size() == 0) chk("R2 random surplus word", dataOut, 36'h0);
              else begin ren = 1; pend = 1; expd = q.pop_front(); end
            end
            if (wrDone && q.size() == 0 && !pend) break;
          end
        end
        ren = 0;
      end
    join
    settle();
    chk("R2 random drained", {35'h0, emptyN}, 36'h0);
  endtask

  initial begin
    #(CLK_W * 150000);
    errors++;
    $display("FAIL watchdog expired actual running expected done");
    summary();
  end

  initial begin
    logic [35:0] v, last;
    int waitCyc;
    void'($urandom(32'd1234));

    // ---------------- standard mode ----------------
    doReset(1'b0);
    chk("R1 fullN", {35'h0, fullN}, 36'h1);
    chk("R1 emptyN", {35'h0, emptyN}, 36'h0);
    chk("R1 pafN", {35'h0, pafN}, 36'h1);
    chk("R1 paeN", {35'h0, paeN}, 36'h0);
    readOfs(v); chk("R1 default ae offset", v, 36'(DEF_AE));
    readOfs(v); chk("R1 default af offset", v, 36'(DEF_AF));
    chk("R6 readback leaves fifo empty", {35'h0, emptyN}, 36'h0);

    loadOfs(NEW_AE);
    loadOfs(NEW_AF);
    settle();
    chk("R5 load leaves fifo empty", {35'h0, emptyN}, 36'h0);
    chk("R5 load leaves full clear", {35'h0, fullN}, 36'h1);
    readOfs(v); chk("R5 ae offset loaded first", v, 36'(NEW_AE));
    readOfs(v); chk("R5 af offset loaded second", v, 36'(NEW_AF));

    for (int k = 1; k <= DEPTH; k++) begin
      writeWord(pattern(k));
      settle();
      chk("R7 fill pafN", {35'h0, pafN}, {35'h0, expPafN(k, NEW_AF)});
      chk("R8 fill paeN", {35'h0, paeN}, {35'h0, expPaeN(k, NEW_AE)});
      chk("R3 fill fullN", {35'h0, fullN}, {35'h0, k != DEPTH});
    end
    writeWord(36'hB_BAD0_BAD0);
    settle();
    chk("R3 full stays full", {35'h0, fullN}, 36'h0);
    readOfs(v); chk("R6 readback while full ae", v, 36'(NEW_AE));
    readOfs(v); chk("R6 readback while full af", v, 36'(NEW_AF));
    settle();
    chk("R6 readback consumed nothing", {35'h0, fullN}, 36'h0);

    for (int k = 1; k <= DEPTH; k++) begin
      int lvl;
      lvl = DEPTH - k;
      readWord();
      chk("R2 R3 drain order", dataOut, pattern(k));
      if (lvl == DEPTH - NEW_AF - 1) begin
        waitCyc = 0;
        while (!pafN && waitCyc < 8) begin @(negedge wclk); waitCyc++; end
        chk("R7 af release within four write cycles", 36'(waitCyc <= 4), 36'h1);
      end
      settle();
      chk("R7 drain pafN", {35'h0, pafN}, {35'h0, expPafN(lvl, NEW_AF)});
      chk("R8 drain paeN", {35'h0, paeN}, {35'h0, expPaeN(lvl, NEW_AE)});
      chk("R2 drain emptyN", {35'h0, emptyN}, {35'h0, lvl != 0});
    end
    last = pattern(DEPTH);
    readWord();
    chk("R4 empty read keeps output", dataOut, last);
    writeWord(36'h3_1234_5678);
    settle();
    readWord();
    chk("R4 empty read consumed nothing", dataOut, 36'h3_1234_5678);
    @(negedge rclk); oe = 0; #1;
    chk("R10 oe low gives zero", dataOut, 36'h0);
    oe = 1; #1;
    chk("R10 oe restored", dataOut, 36'h3_1234_5678);

    randomTraffic(1'b0);

    // ---------------- fall-through mode ----------------
    doReset(1'b1);
    readOfs(v); chk("R1 fwft default ae offset", v, 36'(DEF_AE));
    readOfs(v); chk("R1 fwft default af offset", v, 36'(DEF_AF));
    writeWord(pattern(1));
    settle();
    chk("R9 first word falls through", dataOut, pattern(1));
    chk("R9 emptyN with held word", {35'h0, emptyN}, 36'h1);
    for (int k = 2; k <= DEPTH + 1; k++) begin
      writeWord(pattern(k));
      settle();
      chk("R9 fwft pafN", {35'h0, pafN}, {35'h0, expPafN(k - 1, DEF_AF)});
      chk("R9 fwft fullN", {35'h0, fullN}, {35'h0, k != DEPTH + 1});
    end
    writeWord(36'hB_BAD1_BAD1);
    settle();
    for (int k = 1; k <= DEPTH + 1; k++) begin
      chk("R9 fwft drain order", dataOut, pattern(k));
      readWord();
      settle();
      chk("R8 fwft drain paeN", {35'h0, paeN},
          {35'h0, expPaeN(DEPTH + 1 - k, DEF_AE)});
    end
    chk("R9 fwft empty after D+1", {35'h0, emptyN}, 36'h0);

    randomTraffic(1'b1);
    summary();
  end
endmodule